// File: doc/BRIEF.md
# Multi-Rate Fault and Warning Limit Monitor

This block watches a set of stored measurements: output voltage and output current for each rail, one input voltage, several temperatures and a number of auxiliary inputs. Four programmable limits apply to each measurement: an over-fault, an over-warning, an under-warning and an under-fault. Each class of quantity is tested on its own free-running interval. All intervals are built from a shared microsecond tick that is divided down from the system clock. None of them is aligned with the converter that fills the result registers. A test always reads whatever result is in the register at that moment.

Any crossing latches a sticky warning or fault bit for that quantity. It also queues one event for a downstream fault-response handler. The event carries the quantity index and a severity flag. When several quantities trip in the same test, their events leave one per clock, lowest index first. The rail count sets two things. It sets which per-rail quantities are tested at all, and it stretches the current-test interval in proportion to the number of rails.

Top module: `fault_limit_monitor`

## Requirements
- R1: After reset, every warning and fault status bit is 0 and no event is presented.
- R2: Output-voltage quantities are tested once every VOUT_US microseconds. A microsecond is CLK_PER_US clock cycles of a free-running divider started at reset.
- R3: Output-current quantities are tested once every IOUT_US_PER_RAIL × rail count microseconds. With a rail count of 0, no current test ever happens. A rail count above N_RAILS is treated as N_RAILS.
- R4: The input voltage is tested every VIN_US microseconds. The temperatures are tested every TEMP_US microseconds and the auxiliary inputs every AUX_US microseconds. Each interval runs on its own, counted from reset.
- R5: The over tests trip only when the measurement is strictly greater than the over limit. The under tests trip only when it is strictly less than the under limit, all values unsigned. A measurement equal to a limit trips nothing.
- R6: A test that crosses a warning limit sets that quantity's warning bit. A test that crosses a fault limit sets its fault bit. Both stay set until cleared, even after the measurement returns within limits.
- R7: Writing 1 to a bit of a clear input clears the matching status bit on the next edge. If a test sets that bit on the same edge, the bit stays set.
- R8: Each test that crosses any limit of a quantity yields exactly one event for it. The event has evt_valid_o high for one cycle and evt_idx_o set to the quantity index. evt_flt_o is 1 if a fault limit was crossed and 0 if only a warning limit was crossed. Quantity indices run as follows: output voltage of rail r is r; output current of rail r is N_RAILS+r; the input voltage is 2·N_RAILS; temperature k is 2·N_RAILS+1+k; auxiliary input k is 2·N_RAILS+1+N_TEMP+k. When no other events are waiting, the event appears in the cycle after the test edge.
- R9: Events from one test go out in ascending index order, one per clock, with no gap.
- R10: Voltage and current quantities of rail r are not tested, and never change status or raise events, while r ≥ rail count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rail_cnt_i | input | $clog2(N_RAILS+1) | Number of enabled rails |
| meas_i | input | NQ·MEAS_W | Latest stored result per quantity, quantity q at bits q·MEAS_W upward |
| ov_flt_lim_i | input | NQ·MEAS_W | Over-fault limit per quantity |
| ov_wrn_lim_i | input | NQ·MEAS_W | Over-warning limit per quantity |
| un_wrn_lim_i | input | NQ·MEAS_W | Under-warning limit per quantity |
| un_flt_lim_i | input | NQ·MEAS_W | Under-fault limit per quantity |
| clr_wrn_i | input | NQ | Write-one-to-clear for warning bits |
| clr_flt_i | input | NQ | Write-one-to-clear for fault bits |
| wrn_o | output | NQ | Sticky warning status |
| flt_o | output | NQ | Sticky fault status |
| evt_valid_o | output | 1 | Event strobe |
| evt_idx_o | output | max(1,$clog2(NQ)) | Index of the quantity in the event |
| evt_flt_o | output | 1 | Event severity: 1 fault, 0 warning |

NQ = 2·N_RAILS + 1 + N_TEMP + N_AUX.

## Verification
The hardest case to reach from the ports is a clear that arrives on exactly the edge where a test sets the same bit. The test timers cannot be seen directly. To reach this case, the bench takes the cycle of one input-voltage event and adds the interval from R4. It then raises the clear in the cycle just before the next test edge. A second hard case is several quantities tripping on the same test. Temperature and auxiliary intervals are given equal lengths, so both classes are tested on the same edge; three quantities from those classes are then driven out of limits, and the bench expects events on consecutive cycles. Rail gating is reached by lowering the rail count while disabled rails carry values far out of limits.

// File: rtl/flm_pkg.sv
package flm_pkg;
  localparam int NUM_CLS  = 5;
  localparam int CLS_VOUT = 0;
  localparam int CLS_IOUT = 1;
  localparam int CLS_VIN  = 2;
  localparam int CLS_TEMP = 3;
  localparam int CLS_AUX  = 4;

  typedef struct packed {
    logic ov_f;
    logic ov_w;
    logic un_w;
    logic un_f;
  } cmp_res_t;
endpackage

// File: rtl/flm_us_tick.sv
module flm_us_tick #(
  parameter int CLK_PER_US = 50,
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [PW-1:0] cnt_q;

  assign tick_o = (cnt_q == PW'(CLK_PER_US - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/flm_interval_timer.sv
module flm_interval_timer #(
  parameter int TW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [TW-1:0] period_i,
  output logic          due_o
);
  logic [TW-1:0] cnt_q;
  logic          live;
  logic          wrap;

  assign live  = (period_i != '0);
  // >= keeps the counter sane when the period shrinks at run time
  assign wrap  = (cnt_q >= period_i - TW'(1));
  assign due_o = tick_i & live & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!live)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= wrap ? '0 : cnt_q + TW'(1);
  end
endmodule

// File: rtl/flm_limit_cmp.sv
module flm_limit_cmp
  import flm_pkg::*;
#(
  parameter int NQ = 1,
  parameter int W  = 16
) (
  input  logic [NQ*W-1:0]   meas_i,
  input  logic [NQ*W-1:0]   ov_flt_i,
  input  logic [NQ*W-1:0]   ov_wrn_i,
  input  logic [NQ*W-1:0]   un_wrn_i,
  input  logic [NQ*W-1:0]   un_flt_i,
  output cmp_res_t [NQ-1:0] res_o
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [W-1:0] m;
    assign m = meas_i[q*W +: W];
    assign res_o[q].ov_f = (m > ov_flt_i[q*W +: W]);
    assign res_o[q].ov_w = (m > ov_wrn_i[q*W +: W]);
    assign res_o[q].un_w = (m < un_wrn_i[q*W +: W]);
    assign res_o[q].un_f = (m < un_flt_i[q*W +: W]);
  end
endmodule

// File: rtl/flm_evt_arb.sv
module flm_evt_arb #(
  parameter int NQ = 2,
  parameter int IW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NQ-1:0] trip_i,
  input  logic [NQ-1:0] sev_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic          flt_o
);
  logic [NQ-1:0] pend_q, sev_q, pop;
  logic [IW-1:0] sel;
  logic          found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      if (pend_q[i] && !found) begin
        found = 1'b1;
        sel   = IW'(i);
      end
    end
  end

  always_comb begin
    pop = '0;
    if (found) pop[sel] = 1'b1;
  end

  assign valid_o = found;
  assign idx_o   = sel;
  assign flt_o   = found & sev_q[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      sev_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~pop) | trip_i;
      for (int i = 0; i < NQ; i++) begin
        if (trip_i[i])   sev_q[i] <= sev_i[i] | (pend_q[i] & ~pop[i] & sev_q[i]);
        else if (pop[i]) sev_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fault_limit_monitor.sv
module fault_limit_monitor
  import flm_pkg::*;
#(
  parameter int N_RAILS          = 4,
  parameter int N_TEMP           = 5,
  parameter int N_AUX            = 1,
  parameter int MEAS_W           = 16,
  parameter int CLK_PER_US       = 50,
  parameter int VOUT_US          = 200,
  parameter int IOUT_US_PER_RAIL = 200,
  parameter int VIN_US           = 1000,
  parameter int TEMP_US          = 100000,
  parameter int AUX_US           = 100000,
  localparam int NQ  = 2*N_RAILS + 1 + N_TEMP + N_AUX,
  localparam int IW  = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int RCW = $clog2(N_RAILS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [RCW-1:0]       rail_cnt_i,
  input  logic [NQ*MEAS_W-1:0] meas_i,
  input  logic [NQ*MEAS_W-1:0] ov_flt_lim_i,
  input  logic [NQ*MEAS_W-1:0] ov_wrn_lim_i,
  input  logic [NQ*MEAS_W-1:0] un_wrn_lim_i,
  input  logic [NQ*MEAS_W-1:0] un_flt_lim_i,
  input  logic [NQ-1:0]        clr_wrn_i,
  input  logic [NQ-1:0]        clr_flt_i,
  output logic [NQ-1:0]        wrn_o,
  output logic [NQ-1:0]        flt_o,
  output logic                 evt_valid_o,
  output logic [IW-1:0]        evt_idx_o,
  output logic                 evt_flt_o
);
  localparam int VIN_Q   = 2*N_RAILS;
  localparam int TEMP_Q0 = VIN_Q + 1;
  localparam int AUX_Q0  = TEMP_Q0 + N_TEMP;
  localparam int PSUM    = VOUT_US + IOUT_US_PER_RAIL*N_RAILS + VIN_US + TEMP_US + AUX_US;
  localparam int TW      = $clog2(PSUM + 1);

  logic                 us_tick;
  logic [RCW-1:0]       rc_eff;
  logic [TW-1:0]        per_v [NUM_CLS];
  logic [NUM_CLS-1:0]   due;
  logic [N_RAILS-1:0]   rail_en;
  logic [NQ-1:0]        chk_en, hit_wrn, hit_flt;
  cmp_res_t [NQ-1:0]    cmp;
  logic [NQ-1:0]        wrn_q, flt_q;

  assign rc_eff = (rail_cnt_i > RCW'(N_RAILS)) ? RCW'(N_RAILS) : rail_cnt_i;

  flm_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk_i, .rst_ni, .tick_o(us_tick)
  );

  always_comb begin
    per_v[CLS_VOUT] = TW'(VOUT_US);
    per_v[CLS_IOUT] = TW'(IOUT_US_PER_RAIL) * TW'(rc_eff);
    per_v[CLS_VIN]  = TW'(VIN_US);
    per_v[CLS_TEMP] = TW'(TEMP_US);
    per_v[CLS_AUX]  = TW'(AUX_US);
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_tmr
    flm_interval_timer #(.TW(TW)) u_tmr (
      .clk_i, .rst_ni, .tick_i(us_tick), .period_i(per_v[c]), .due_o(due[c])
    );
  end

  for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
    assign rail_en[r] = (RCW'(r) < rc_eff);
  end

  for (genvar q = 0; q < NQ; q++) begin : g_map
    if (q < N_RAILS) begin : g_vout
      assign chk_en[q] = due[CLS_VOUT] & rail_en[q];
    end else if (q < VIN_Q) begin : g_iout
      assign chk_en[q] = due[CLS_IOUT] & rail_en[q-N_RAILS];
    end else if (q == VIN_Q) begin : g_vin
      assign chk_en[q] = due[CLS_VIN];
    end else if (q < AUX_Q0) begin : g_temp
      assign chk_en[q] = due[CLS_TEMP];
    end else begin : g_aux
      assign chk_en[q] = due[CLS_AUX];
    end
  end

  flm_limit_cmp #(.NQ(NQ), .W(MEAS_W)) u_cmp (
    .meas_i   (meas_i),
    .ov_flt_i (ov_flt_lim_i),
    .ov_wrn_i (ov_wrn_lim_i),
    .un_wrn_i (un_wrn_lim_i),
    .un_flt_i (un_flt_lim_i),
    .res_o    (cmp)
  );

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      hit_flt[q] = chk_en[q] & (cmp[q].ov_f | cmp[q].un_f);
      hit_wrn[q] = chk_en[q] & (cmp[q].ov_w | cmp[q].un_w);
    end
  end

  // set beats clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wrn_q <= '0;
      flt_q <= '0;
    end else begin
      wrn_q <= (wrn_q & ~clr_wrn_i) | hit_wrn;
      flt_q <= (flt_q & ~clr_flt_i) | hit_flt;
    end
  end

  assign wrn_o = wrn_q;
  assign flt_o = flt_q;

  flm_evt_arb #(.NQ(NQ), .IW(IW)) u_arb (
    .clk_i, .rst_ni,
    .trip_i  (hit_flt | hit_wrn),
    .sev_i   (hit_flt),
    .valid_o (evt_valid_o),
    .idx_o   (evt_idx_o),
    .flt_o   (evt_flt_o)
  );
endmodule

// File: rtl/fault_limit_monitor_chk.sv
module fault_limit_monitor_chk #(
  parameter int N_RAILS  = 4,
  parameter int NQ       = 15,
  parameter int IW       = 4,
  parameter int RCW      = 3,
  parameter int VOUT_CYC = 10000
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [RCW-1:0] rail_cnt_i,
  input logic [NQ-1:0]  clr_wrn_i,
  input logic [NQ-1:0]  clr_flt_i,
  input logic [NQ-1:0]  wrn_o,
  input logic [NQ-1:0]  flt_o,
  input logic           evt_valid_o,
  input logic [IW-1:0]  evt_idx_o,
  input logic           vout_due_i
);
  int unsigned cnt_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= 0;
      seen_q <= 1'b0;
    end else if (vout_due_i) begin
      cnt_q  <= 1;
      seen_q <= 1'b1;
    end else if (cnt_q != 32'hffff_ffff) begin
      cnt_q  <= cnt_q + 1;
    end
  end

  // R2
  vout_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vout_due_i && seen_q) |-> (cnt_q == VOUT_CYC));

  // R6
  flt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(flt_o) & ~flt_o & ~$past(clr_flt_i)) == '0));

  // R6
  wrn_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(wrn_o) & ~wrn_o & ~$past(clr_wrn_i)) == '0));

  // R8
  evt_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> ({1'b0, evt_idx_o} < (IW+1)'(NQ)));

  for (genvar r = 0; r < N_RAILS; r++) begin : g_gate
    // R10
    vout_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(flt_o[r]) || $rose(wrn_o[r])) |-> ($past(rail_cnt_i) > RCW'(r)));
    // R3
    iout_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(flt_o[N_RAILS+r]) || $rose(wrn_o[N_RAILS+r])) |-> ($past(rail_cnt_i) > RCW'(r)));
  end
endmodule

bind fault_limit_monitor fault_limit_monitor_chk #(
  .N_RAILS  (N_RAILS),
  .NQ       (NQ),
  .IW       (IW),
  .RCW      (RCW),
  .VOUT_CYC (VOUT_US * CLK_PER_US)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rail_cnt_i  (rail_cnt_i),
  .clr_wrn_i   (clr_wrn_i),
  .clr_flt_i   (clr_flt_i),
  .wrn_o       (wrn_o),
  .flt_o       (flt_o),
  .evt_valid_o (evt_valid_o),
  .evt_idx_o   (evt_idx_o),
  .vout_due_i  (due[0])
);

// File: tb/fault_limit_monitor_tb_top.sv
module fault_limit_monitor_tb_top;
  localparam int NR = 4, NT = 5, NA = 1, W = 16;
  localparam int CPU = 2;
  localparam int NQ = 2*NR + 1 + NT + NA;
  localparam int IW = $clog2(NQ);
  localparam int RCW = $clog2(NR + 1);
  localparam int VOUT_CYC = 20 * CPU;
  localparam int IOUT_CYC_PER_RAIL = 20 * CPU;
  localparam int VIN_CYC = 100 * CPU;
  localparam int TEMP_CYC = 1000 * CPU;

  typedef struct packed {
    int idx;
    bit flt;
    int gap;
    bit b2b;
    int req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RCW-1:0] rail_cnt = RCW'(NR);
  logic [NQ*W-1:0] meas, ovf, ovw, unw, unf;
  logic [NQ-1:0] clr_w = '0, clr_f = '0;
  logic [NQ-1:0] wrn, flt;
  logic evt_v, evt_f;
  logic [IW-1:0] evt_i;

  int tests = 0, fails = 0, unexp = 0, cyc = 0, last_any = -10;
  int last_cyc [NQ];
  bit seen [NQ];
  exp_t exp_q[$];
  exp_t it;
  int mi;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fault_limit_monitor #(
    .N_RAILS(NR), .N_TEMP(NT), .N_AUX(NA), .MEAS_W(W), .CLK_PER_US(CPU),
    .VOUT_US(20), .IOUT_US_PER_RAIL(20), .VIN_US(100), .TEMP_US(1000), .AUX_US(1000)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rail_cnt_i(rail_cnt), .meas_i(meas),
    .ov_flt_lim_i(ovf), .ov_wrn_lim_i(ovw), .un_wrn_lim_i(unw), .un_flt_lim_i(unf),
    .clr_wrn_i(clr_w), .clr_flt_i(clr_f), .wrn_o(wrn), .flt_o(flt),
    .evt_valid_o(evt_v), .evt_idx_o(evt_i), .evt_flt_o(evt_f)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && evt_v) begin
      mi = int'(evt_i);
      if (exp_q.size() == 0) begin
        unexp++;
        tests++; fails++;
        $display("FAIL R8 unexpected event idx: actual %0d expected none", mi);
      end else begin
        it = exp_q.pop_front();
        tests++;
        if (mi != it.idx || evt_f != it.flt) begin
          fails++;
          $display("FAIL R%0d event idx/sev: actual %0d/%0d expected %0d/%0d",
                   it.req, mi, evt_f, it.idx, it.flt);
        end else if (it.gap != 0 && (!seen[mi] || cyc - last_cyc[mi] != it.gap)) begin
          fails++;
          $display("FAIL R%0d interval: actual %0d expected %0d", it.req, cyc - last_cyc[mi], it.gap);
        end else if (it.b2b && cyc - last_any != 1) begin
          fails++;
          $display("FAIL R%0d back-to-back: actual %0d expected 1", it.req, cyc - last_any);
        end
      end
      if (mi < NQ) begin
        seen[mi] = 1'b1;
        last_cyc[mi] = cyc;
      end
      last_any = cyc;
    end
  end

  task automatic push(input int idx, input bit f, input int gap, input bit b2b, input int req);
    exp_t e;
    e.idx = idx; e.flt = f; e.gap = gap; e.b2b = b2b; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic drain(input int max, input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < max) begin
      step(1);
      n++;
    end
    chk(exp_q.size() == 0, req, "expected events not seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic set_m(input int idx, input int val);
    meas[idx*W +: W] = W'(val);
  endtask

  task automatic pulse_clr(input logic [NQ-1:0] w, input logic [NQ-1:0] f);
    clr_w = w; clr_f = f;
    step(1);
    clr_w = '0; clr_f = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int c, u0;
    for (int q = 0; q < NQ; q++) begin seen[q] = 1'b0; last_cyc[q] = 0; end
    ovf = {NQ{W'(3000)}}; ovw = {NQ{W'(2500)}};
    unw = {NQ{W'(1500)}}; unf = {NQ{W'(1000)}};
    meas = {NQ{W'(2000)}};
    step(3);
    // R1 reset state
    chk(wrn == '0, "R1", "warn after reset", longint'(wrn), 0);
    chk(flt == '0, "R1", "fault after reset", longint'(flt), 0);
    chk(evt_v == 1'b0, "R1", "event in reset", evt_v, 0);
    rst_n = 1'b1;
    step(2);
    chk(wrn == '0 && flt == '0 && !evt_v, "R1", "status after release", longint'(flt), 0);

    // R2 vout over-warning on rail 1, interval
    set_m(1, 2600);
    push(1, 0, 0, 0, 2); push(1, 0, VOUT_CYC, 0, 2); push(1, 0, VOUT_CYC, 0, 2);
    drain(200, "R2");
    set_m(1, 2000);
    step(100);
    // R6 sticky after return in range
    chk(wrn[1] == 1'b1, "R6", "warn sticky", wrn[1], 1);
    chk(flt[1] == 1'b0, "R6", "no fault on warn only", flt[1], 0);

    // R5 equal to over-fault limit trips warn only; R4 vin interval
    set_m(8, 3000);
    push(8, 0, 0, 0, 5); push(8, 0, VIN_CYC, 0, 4);
    drain(600, "R4");
    chk(flt[8] == 1'b0, "R5", "fault at equality", flt[8], 0);
    set_m(8, 1500);
    pulse_clr(NQ'(1) << 8, '0);
    chk(wrn[8] == 1'b0, "R7", "warn cleared", wrn[8], 0);
    u0 = unexp;
    step(450);
    chk(wrn[8] == 1'b0, "R5", "warn at under equality", wrn[8], 0);
    chk(unexp == u0, "R5", "events at equality", unexp - u0, 0);

    // R7 set wins over clear on the test edge
    set_m(8, 1499);
    push(8, 0, 0, 0, 5);
    drain(400, "R5");
    c = last_cyc[8];
    push(8, 0, VIN_CYC, 0, 7);
    while (cyc != c + VIN_CYC - 1) step(1);
    clr_w = NQ'(1) << 8;
    step(1);
    clr_w = '0;
    chk(wrn[8] == 1'b1, "R7", "set beats clear", wrn[8], 1);
    drain(50, "R7");
    set_m(8, 2000);
    pulse_clr(NQ'(1) << 8, '0);
    chk(wrn[8] == 1'b0, "R7", "clear in quiet time", wrn[8], 0);

    // R3 current interval scales with rail count; R8 fault severity
    set_m(4, 3100);
    push(4, 1, 0, 0, 8); push(4, 1, IOUT_CYC_PER_RAIL * 4, 0, 3);
    drain(800, "R3");
    chk(flt[4] && wrn[4], "R6", "fault and warn both latched", {flt[4], wrn[4]}, 3);
    rail_cnt = RCW'(2);
    push(4, 1, 0, 0, 3); push(4, 1, IOUT_CYC_PER_RAIL * 2, 0, 3);
    drain(400, "R3");
    set_m(4, 2000);
    step(5);

    // R10 disabled rails
    pulse_clr('1, '1);
    chk(flt == '0 && wrn == '0, "R7", "clear all", longint'(flt), 0);
    set_m(3, 3500); set_m(7, 3500);
    u0 = unexp;
    step(300);
    chk(flt[3] == 1'b0 && flt[7] == 1'b0, "R10", "disabled rail fault", {flt[3], flt[7]}, 0);
    chk(unexp == u0, "R10", "events from disabled rail", unexp - u0, 0);
    set_m(3, 2000); set_m(7, 2000);

    // R3 rail count 0 stops current tests
    rail_cnt = '0;
    set_m(4, 3500); set_m(0, 3500);
    step(400);
    chk(flt[4] == 1'b0, "R3", "current fault with zero rails", flt[4], 0);
    chk(flt[0] == 1'b0, "R10", "vout fault with zero rails", flt[0], 0);
    chk(unexp == u0, "R3", "events with zero rails", unexp - u0, 0);
    set_m(4, 2000); set_m(0, 2000);
    step(2);
    rail_cnt = RCW'(NR);

    // R9 several quantities on one test, ascending, one per clock
    set_m(9, 900); set_m(10, 2600); set_m(14, 3100);
    push(9, 1, 0, 0, 9); push(10, 0, 0, 1, 9); push(14, 1, 0, 1, 9);
    push(9, 1, TEMP_CYC, 0, 4); push(10, 0, TEMP_CYC, 1, 9); push(14, 1, TEMP_CYC, 1, 4);
    drain(4500, "R9");
    set_m(9, 2000); set_m(10, 2000); set_m(14, 2000);
    step(3);
    chk(flt[9] == 1'b1, "R6", "temp under fault", flt[9], 1);
    chk(wrn[10] == 1'b1 && flt[10] == 1'b0, "R6", "temp warn only", {wrn[10], flt[10]}, 2);
    chk(flt[14] == 1'b1, "R6", "aux fault", flt[14], 1);
    step(50);
    chk(unexp == u0, "R8", "stray events", unexp - u0, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule